// File: doc/BRIEF.md
# Condition-Code Instruction Gate

This block decides, for every instruction passing through a pipeline stage, whether that instruction is allowed to take effect. Each instruction carries a 4-bit condition field. The block compares that field with the four status flags (negative, zero, carry, overflow) left by the most recent compare or flag-setting operation. Because any instruction can be gated this way, a short conditional sequence needs no branch.

The block has three internal stages:

- A decoder maps the condition field onto a one-hot class and a polarity bit.
- An evaluator combines the class with the flags.
- A register stage turns the outcome into the enables of the gated instruction.

A condition that fails clears both the register-write enable and the flag-update enable, so the instruction becomes a no-op. The flags themselves, the fetch logic and the register file sit outside this block; the flags arrive as an input.

Equality, unsigned ordering and signed ordering each come from their own flag combination. An always-true code is also provided. The codes left unassigned never execute by default, and a parameter can instead make them execute.

Top module: `cond_gate`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `valid_out`, `exec_pass`, `wr_en` and `flg_en` are all 0.
- R2: A condition presented with `valid_in`=1 at a rising edge produces its result on `valid_out`/`exec_pass`/`wr_en`/`flg_en` right after that same edge. It holds there until the next edge. Exactly one result appears for each accepted input, in order.
- R3: The flag input is laid out as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V. Code 4'b0000 (equal) passes when Z=1, and code 4'b0001 (not equal) passes when Z=0.
- R4: Code 4'b0010 (unsigned higher-or-same) passes when C=1, and code 4'b0011 (unsigned lower) passes when C=0.
- R5: Code 4'b1000 (unsigned higher) passes when C=1 and Z=0, and code 4'b1001 (unsigned lower-or-same) passes when C=0 or Z=1.
- R6: Code 4'b1010 (signed greater-or-equal) passes when N equals V, and code 4'b1011 (signed less) passes when N differs from V.
- R7: Code 4'b1100 (signed greater) passes when Z=0 and N equals V, and code 4'b1101 (signed less-or-equal) passes when Z=1 or N differs from V.
- R8: Code 4'b1110 (always) passes for every flag value.
- R9: With the default `RSV_PASS`=0, the unassigned codes 4'b0100 to 4'b0111 and 4'b1111 never pass, whatever the flags.
- R10: For a valid input, `wr_en` equals pass AND `wr_req`, and `flg_en` equals pass AND `flg_req`. A failed condition therefore forces both enables to 0.
- R11: A cycle with `valid_in`=0 gives `valid_out`, `exec_pass`, `wr_en` and `flg_en` equal to 0 after the next edge, whatever the code, flags and request inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | An instruction is present this cycle |
| cond_code | input | 4 | Condition field of the instruction |
| flags_nzcv | input | 4 | Current flags: N, Z, C, V from bit 3 down to bit 0 |
| wr_req | input | 1 | Instruction wants to write a register |
| flg_req | input | 1 | Instruction wants to update the flags |
| valid_out | output | 1 | Registered copy of `valid_in` |
| exec_pass | output | 1 | Condition held for the registered instruction |
| wr_en | output | 1 | Gated register-write enable |
| flg_en | output | 1 | Gated flag-update enable |

## Verification
Every result is due exactly one rising edge after its inputs are sampled. The driver applies inputs on a falling edge and pushes the expected pass bit and enables into a queue. The monitor samples on the next falling edge, half a period after the capturing edge, and pops one item whenever `valid_out` is high. In idle cycles it instead checks that all outputs are low.

The stimulus sweeps all 16 codes against all 16 flag values. The request bits vary with the sweep, and bubble cycles carrying asserted requests are interleaved.

// File: rtl/cond_gate_pkg.sv
package cond_gate_pkg;

   localparam int CODE_W = 4;
   localparam int FLAG_W = 4;

   // flag bit positions inside the NZCV word
   localparam int FLG_N = 3;
   localparam int FLG_Z = 2;
   localparam int FLG_C = 1;
   localparam int FLG_V = 0;

   typedef enum logic [CODE_W-1:0] {
      CC_EQ = 4'b0000,
      CC_NE = 4'b0001,
      CC_HS = 4'b0010,
      CC_LO = 4'b0011,
      CC_HI = 4'b1000,
      CC_LS = 4'b1001,
      CC_GE = 4'b1010,
      CC_LT = 4'b1011,
      CC_GT = 4'b1100,
      CC_LE = 4'b1101,
      CC_AL = 4'b1110
   } cc_e;

   // condition classes: a pair of codes shares a class, the low code bit flips it
   localparam int CLS_ZERO   = 0;
   localparam int CLS_CARRY  = 1;
   localparam int CLS_HIGHER = 2;
   localparam int CLS_SGE    = 3;
   localparam int CLS_SGT    = 4;
   localparam int CLS_ALWAYS = 5;
   localparam int CLS_RSV    = 6;
   localparam int NUM_CLS    = 7;

   typedef struct packed {
      logic [NUM_CLS-1:0] sel;
      logic               inv;
   } cls_t;

endpackage

// File: rtl/cond_decode.sv
module cond_decode
   import cond_gate_pkg::*;
#(
   parameter int CW = CODE_W
) (
   input  logic [CW-1:0] code_i,
   output cls_t          cls_o
);

   generate
      if (CW != 4) begin : g_bad_cw
         $error("cond_decode: code width must be 4");
      end
   endgenerate

   always_comb begin
      cls_o.sel = '0;
      cls_o.inv = 1'b0;
      case (code_i)
         CC_EQ, CC_NE: begin
            cls_o.sel[CLS_ZERO] = 1'b1;
            cls_o.inv           = code_i[0];
         end
         CC_HS, CC_LO: begin
            cls_o.sel[CLS_CARRY] = 1'b1;
            cls_o.inv            = code_i[0];
         end
         CC_HI, CC_LS: begin
            cls_o.sel[CLS_HIGHER] = 1'b1;
            cls_o.inv             = code_i[0];
         end
         CC_GE, CC_LT: begin
            cls_o.sel[CLS_SGE] = 1'b1;
            cls_o.inv          = code_i[0];
         end
         CC_GT, CC_LE: begin
            cls_o.sel[CLS_SGT] = 1'b1;
            cls_o.inv          = code_i[0];
         end
         CC_AL: begin
            cls_o.sel[CLS_ALWAYS] = 1'b1;
         end
         default: begin
            cls_o.sel[CLS_RSV] = 1'b1;
         end
      endcase
   end

   // R9: every code lands in exactly one class, reserved codes included
   always_comb begin
      if (!$isunknown(code_i)) begin
         one_class_chk: assert ($countones(cls_o.sel) == 1)
            else $error("cond_decode: class select not one-hot");
      end
   end

endmodule

// File: rtl/cond_eval.sv
module cond_eval
   import cond_gate_pkg::*;
#(
   parameter int FW       = FLAG_W,
   parameter bit RSV_PASS = 1'b0
) (
   input  cls_t          cls_i,
   input  logic [FW-1:0] flags_i,
   output logic          pass_o
);

   generate
      if (FW != 4) begin : g_bad_fw
         $error("cond_eval: flag width must be 4");
      end
   endgenerate

   logic               f_n, f_z, f_c, f_v;
   logic               sgn_ok;
   logic [NUM_CLS-1:0] base;
   logic               raw;
   logic               rsv_val;

   assign f_n = flags_i[FLG_N];
   assign f_z = flags_i[FLG_Z];
   assign f_c = flags_i[FLG_C];
   assign f_v = flags_i[FLG_V];

   generate
      if (RSV_PASS) begin : g_rsv_exec
         assign rsv_val = 1'b1;
      end else begin : g_rsv_skip
         assign rsv_val = 1'b0;
      end
   endgenerate

   assign sgn_ok = ~(f_n ^ f_v);

   always_comb begin
      base                 = '0;
      base[CLS_ZERO]       = f_z;
      base[CLS_CARRY]      = f_c;
      base[CLS_HIGHER]     = f_c & ~f_z;
      base[CLS_SGE]        = sgn_ok;
      base[CLS_SGT]        = sgn_ok & ~f_z;
      base[CLS_ALWAYS]     = 1'b1;
      base[CLS_RSV]        = rsv_val;
   end

   assign raw    = |(cls_i.sel & base);
   assign pass_o = raw ^ cls_i.inv;

endmodule

// File: rtl/gate_stage.sv
module gate_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic vld_i,
   input  logic pass_i,
   input  logic wr_req_i,
   input  logic flg_req_i,
   output logic vld_o,
   output logic pass_o,
   output logic wr_o,
   output logic flg_o
);

   logic take;

   assign take = vld_i & pass_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         pass_o <= 1'b0;
         wr_o   <= 1'b0;
         flg_o  <= 1'b0;
      end else begin
         vld_o  <= vld_i;
         pass_o <= take;
         wr_o   <= take & wr_req_i;
         flg_o  <= take & flg_req_i;
      end
   end

endmodule

// File: rtl/cond_gate.sv
module cond_gate
   import cond_gate_pkg::*;
#(
   parameter int CW       = CODE_W,
   parameter int FW       = FLAG_W,
   parameter bit RSV_PASS = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid_in,
   input  logic [CW-1:0] cond_code,
   input  logic [FW-1:0] flags_nzcv,
   input  logic          wr_req,
   input  logic          flg_req,
   output logic          valid_out,
   output logic          exec_pass,
   output logic          wr_en,
   output logic          flg_en
);

   generate
      if (CW != CODE_W || FW != FLAG_W) begin : g_bad_top
         $error("cond_gate: code and flag widths must both be 4");
      end
   endgenerate

   cls_t cls;
   logic pass;

   cond_decode #(.CW(CW)) u_dec (
      .code_i (cond_code),
      .cls_o  (cls)
   );

   cond_eval #(.FW(FW), .RSV_PASS(RSV_PASS)) u_eval (
      .cls_i   (cls),
      .flags_i (flags_nzcv),
      .pass_o  (pass)
   );

   gate_stage u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .vld_i     (valid_in),
      .pass_i    (pass),
      .wr_req_i  (wr_req),
      .flg_req_i (flg_req),
      .vld_o     (valid_out),
      .pass_o    (exec_pass),
      .wr_o      (wr_en),
      .flg_o     (flg_en)
   );

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> (!valid_out && !exec_pass && !wr_en && !flg_en));

   // R2
   one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> valid_out);

   // R8
   always_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && cond_code == CC_AL) |=> exec_pass);

   // R3
   eq_tracks_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && cond_code == CC_EQ) |=> (exec_pass == $past(flags_nzcv[FLG_Z])));

   // R10
   fail_mutes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && cond_code == CC_LT && flags_nzcv[FLG_N] == flags_nzcv[FLG_V])
      |=> (!wr_en && !flg_en));

endmodule

// File: tb/cond_gate_tb.sv
`timescale 1ns/1ps
module cond_gate_tb;

   typedef struct {
      logic  pass;
      logic  wr;
      logic  fl;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       valid_in = 1'b0;
   logic [3:0] cond_code = 4'b0;
   logic [3:0] flags_nzcv = 4'b0;
   logic       wr_req = 1'b0;
   logic       flg_req = 1'b0;
   logic       valid_out, exec_pass, wr_en, flg_en;

   int   checks = 0;
   int   errors = 0;
   bit   mon_on = 1'b0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   cond_gate u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_in   (valid_in),
      .cond_code  (cond_code),
      .flags_nzcv (flags_nzcv),
      .wr_req     (wr_req),
      .flg_req    (flg_req),
      .valid_out  (valid_out),
      .exec_pass  (exec_pass),
      .wr_en      (wr_en),
      .flg_en     (flg_en)
   );

   function automatic logic exp_pass(logic [3:0] c, logic [3:0] f);
      logic n, z, cy, v;
      n = f[3]; z = f[2]; cy = f[1]; v = f[0];
      case (c)
         4'b0000: return z;
         4'b0001: return !z;
         4'b0010: return cy;
         4'b0011: return !cy;
         4'b1000: return cy && !z;
         4'b1001: return !cy || z;
         4'b1010: return n == v;
         4'b1011: return n != v;
         4'b1100: return !z && (n == v);
         4'b1101: return z || (n != v);
         4'b1110: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string code_tag(logic [3:0] c);
      case (c)
         4'b0000, 4'b0001: return "R3";
         4'b0010, 4'b0011: return "R4";
         4'b1000, 4'b1001: return "R5";
         4'b1010, 4'b1011: return "R6";
         4'b1100, 4'b1101: return "R7";
         4'b1110:          return "R8";
         default:          return "R9";
      endcase
   endfunction

   task automatic check(string tag, string what, logic got, logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: %s got %0b exp %0b", tag, what, got, exp);
      end
   endtask

   task automatic send(logic [3:0] c, logic [3:0] f, logic w, logic fl);
      exp_t e;
      @(negedge clk);
      valid_in   = 1'b1;
      cond_code  = c;
      flags_nzcv = f;
      wr_req     = w;
      flg_req    = fl;
      e.pass = exp_pass(c, f);
      e.wr   = e.pass & w;
      e.fl   = e.pass & fl;
      e.tag  = code_tag(c);
      sb.push_back(e);
   endtask

   // R11 stimulus: requests asserted but no valid instruction
   task automatic bubble(logic [3:0] c);
      @(negedge clk);
      valid_in   = 1'b0;
      cond_code  = c;
      flags_nzcv = 4'b1111;
      wr_req     = 1'b1;
      flg_req    = 1'b1;
   endtask

   // monitor: results are due one edge after capture, sampled on the falling edge
   always @(negedge clk) begin
      if (mon_on) begin
         if (valid_out) begin
            if (sb.size() == 0) begin
               check("R2", "unexpected valid_out", 1'b1, 1'b0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(e.tag, "exec_pass", exec_pass, e.pass);
               check("R10", "wr_en", wr_en, e.wr);
               check("R10", "flg_en", flg_en, e.fl);
            end
         end else begin
            check("R11", "idle exec_pass", exec_pass, 1'b0);
            check("R11", "idle wr_en", wr_en, 1'b0);
            check("R11", "idle flg_en", flg_en, 1'b0);
         end
      end
   end

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2: watchdog got hang exp completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state, during reset and in the first cycle after release
      repeat (3) @(negedge clk);
      check("R1", "reset valid_out", valid_out, 1'b0);
      check("R1", "reset exec_pass", exec_pass, 1'b0);
      check("R1", "reset wr_en", wr_en, 1'b0);
      check("R1", "reset flg_en", flg_en, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "post-reset valid_out", valid_out, 1'b0);
      mon_on = 1'b1;

      // full sweep of codes against flags, requests varied
      for (int c = 0; c < 16; c++) begin
         for (int f = 0; f < 16; f++) begin
            logic [3:0] cc;
            logic [3:0] ff;
            cc = 4'(c);
            ff = 4'(f);
            send(cc, ff, ff[0] ^ cc[1], ~ff[1] ^ cc[0]);
            if (f == 7) bubble(cc);
         end
      end

      // R10: both requests set against a passing and a failing condition
      send(4'b1110, 4'b0000, 1'b1, 1'b1);
      send(4'b1011, 4'b0000, 1'b1, 1'b1);
      send(4'b1100, 4'b1001, 1'b1, 1'b1);
      // R11: back-to-back bubbles using the always code
      bubble(4'b1110);
      bubble(4'b1110);
      send(4'b0000, 4'b0100, 1'b1, 1'b0);

      @(negedge clk);
      valid_in = 1'b0;
      repeat (3) @(negedge clk);
      // R2: one result for each accepted input
      check("R2", "queue drained", sb.size() == 0, 1'b1);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule